// File: doc/BRIEF.md
# Multiplexed Segment Display RAM Loader

This block takes display-data bytes from a command front end and stores them in a 24-word by 4-bit display RAM. The selected multiplex mode decides how each byte is spread over the RAM. In static mode a byte covers a single bit row. In the three multiplexed modes it covers two, three or four bit rows of each address. A write pointer and a subaddress counter then step so that the next byte continues where the last one ended.

Several of these loaders can sit on one bus as a cascade. Each one compares its subaddress counter with its strapped hardware subaddress and stores only on a match. Every loader advances its pointer on every byte, so when the pointer runs off the top of the RAM the subaddress counter moves on and the next device in the chain takes over. That handover may fall in the middle of a byte.

In static and 1:2 modes a bank input redirects the writes into the upper bit rows, so a second image can be prepared there. A combinational read port serves the display sequencer.

Top module: `seg_ram_loader`

## Requirements
- R1: After reset every RAM bit reads 0, the pointer is 0 and the subaddress counter is 0. The read port is combinational: `rd_data_o` bit r is row r of address `rd_addr_i`, and a write shows on it right after the clock edge that performs it. Addresses of 24 and above read as 0.
- R2: Static mode (`mode_i`=00) writes byte bit 7 down to bit 0 into row 0 of addresses p to p+7, starting at pointer p. The pointer then advances by 8.
- R3: 1:2 mode (`mode_i`=01) fills rows 0 then 1 of each address, starting with bit 7 in row 0 of address p, across 4 addresses. The pointer then advances by 4.
- R4: 1:3 mode (`mode_i`=10) fills rows 0, 1, 2 of addresses p and p+1, then rows 0 and 1 of p+2. Row 2 of p+2 keeps its old value. The pointer then advances by 3.
- R5: 1:4 mode (`mode_i`=11) fills rows 0 to 3 of addresses p and p+1, MSB first. The pointer then advances by 2.
- R6: A bit is stored only when the subaddress that applies to its address equals `hw_sub_i`. When nothing matches, the RAM is unchanged but the pointer still advances.
- R7: Address arithmetic wraps modulo 24. Any bit that lands past address 23 goes to address 0 and onward, and is stored under the subaddress counter plus one. The stored pointer wraps the same way, and the counter increments whenever the pointer wraps.
- R8: With `bank_i`=1, static mode writes row 2 in place of row 0, and 1:2 mode writes rows 2 and 3 in place of rows 0 and 1. In 1:3 and 1:4 modes `bank_i` has no effect.
- R9: `ptr_load_i` sets the pointer to `ptr_val_i` and `sub_load_i` sets the counter to `sub_val_i`, both for the next byte. A byte presented in the same cycle still uses the old values.
- R10: In a cycle with no byte and no load strobe, the pointer, the counter and the RAM all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Multiplex mode: 00 static, 01 1:2, 10 1:3, 11 1:4 |
| bank_i | input | 1 | Input bank select (upper rows) |
| hw_sub_i | input | 3 | Strapped hardware subaddress |
| ptr_load_i | input | 1 | Load pointer strobe |
| ptr_val_i | input | 5 | Pointer value to load (0 to 23) |
| sub_load_i | input | 1 | Load subaddress counter strobe |
| sub_val_i | input | 3 | Subaddress counter value to load |
| byte_valid_i | input | 1 | Display byte strobe |
| byte_i | input | 8 | Display byte |
| rd_addr_i | input | 5 | Display read address |
| rd_data_o | output | 4 | Four bit rows of the read address |

## Verification
The hardest situation to reach is a byte that crosses address 23 while the subaddress counter sits next to the hardware subaddress. Then the first part of the byte is dropped and the remainder lands at address 0, or the reverse. Directed cases load the pointer to 22 or 23 in 1:3 and static modes, with the counter one below or equal to the strap. Seeded random traffic then mixes pointer loads near the top of the RAM with a two-value subaddress range, so that matches and crossings occur often, and every address is compared after each step.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;

    localparam int ADDR_W = 5;
    localparam int ROW_W  = 2;
    localparam int ROWS   = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'b00,
        MUX_1OF2   = 2'b01,
        MUX_1OF3   = 2'b10,
        MUX_1OF4   = 2'b11
    } mux_mode_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [ROW_W-1:0]  row;
        logic              bit_v;
    } bit_wr_t;

    // active bit rows per address for a mode
    function automatic int rows_of(mux_mode_e m);
        return int'(m) + 1;
    endfunction

    // addresses consumed by one byte
    function automatic int step_of(mux_mode_e m);
        return (BYTE_W + rows_of(m) - 1) / rows_of(m);
    endfunction

    // address offset of byte position j (0 = MSB)
    function automatic int off_of(mux_mode_e m, int j);
        return j / rows_of(m);
    endfunction

    function automatic int row_of(mux_mode_e m, int j);
        return j % rows_of(m);
    endfunction

endpackage

// File: rtl/seg_ld_placer.sv
module seg_ld_placer
    import seg_ld_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int SUB_W = 3
) (
    input  mux_mode_e          mode_i,
    input  logic               bank_i,
    input  logic               valid_i,
    input  logic [BYTE_W-1:0]  data_i,
    input  logic [ADDR_W-1:0]  ptr_i,
    input  logic [SUB_W-1:0]   sub_i,
    input  logic [SUB_W-1:0]   hw_sub_i,
    output bit_wr_t            wr_o [BYTE_W]
);

    logic bank_ok;
    assign bank_ok = bank_i && (mode_i == MUX_STATIC || mode_i == MUX_1OF2);

    for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
        logic [ADDR_W:0]  sum;
        logic             wrap;
        logic [ROW_W-1:0] row;
        always_comb begin
            sum  = {1'b0, ptr_i} + (ADDR_W+1)'(off_of(mode_i, j));
            wrap = (int'(sum) >= DEPTH);
            row  = ROW_W'(row_of(mode_i, j));
            if (bank_ok) row = row + ROW_W'(2);
            wr_o[j].addr  = wrap ? ADDR_W'(int'(sum) - DEPTH) : sum[ADDR_W-1:0];
            wr_o[j].row   = row;
            wr_o[j].bit_v = data_i[BYTE_W-1-j];
            wr_o[j].en    = valid_i && ((sub_i + SUB_W'(wrap)) == hw_sub_i);
        end
    end

endmodule

// File: rtl/seg_ld_ptr.sv
module seg_ld_ptr
    import seg_ld_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int SUB_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  mux_mode_e         mode_i,
    input  logic              valid_i,
    input  logic              ptr_load_i,
    input  logic [ADDR_W-1:0] ptr_val_i,
    input  logic              sub_load_i,
    input  logic [SUB_W-1:0]  sub_val_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [SUB_W-1:0]  sub_o
);

    logic [ADDR_W-1:0] ptr_q, ptr_n;
    logic [SUB_W-1:0]  sub_q, sub_n;
    logic [ADDR_W:0]   sum;

    always_comb begin
        ptr_n = ptr_q;
        sub_n = sub_q;
        sum   = {1'b0, ptr_q} + (ADDR_W+1)'(step_of(mode_i));
        if (valid_i) begin
            if (int'(sum) >= DEPTH) begin
                ptr_n = ADDR_W'(int'(sum) - DEPTH);
                sub_n = sub_q + SUB_W'(1);
            end else begin
                ptr_n = sum[ADDR_W-1:0];
            end
        end
        if (ptr_load_i) ptr_n = ptr_val_i;
        if (sub_load_i) sub_n = sub_val_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            sub_q <= '0;
        end else begin
            ptr_q <= ptr_n;
            sub_q <= sub_n;
        end
    end

    assign ptr_o = ptr_q;
    assign sub_o = sub_q;

endmodule

// File: rtl/seg_ld_ram.sv
module seg_ld_ram
    import seg_ld_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int PORTS = BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bit_wr_t               wr_i [PORTS],
    output logic [DEPTH*ROWS-1:0] image_o
);

    logic [DEPTH*ROWS-1:0] image_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            image_q <= '0;
        end else begin
            for (int p = 0; p < PORTS; p++) begin
                if (wr_i[p].en && int'(wr_i[p].addr) < DEPTH)
                    image_q[int'(wr_i[p].addr)*ROWS + int'(wr_i[p].row)] <= wr_i[p].bit_v;
            end
        end
    end

    assign image_o = image_q;

endmodule

// File: rtl/seg_ram_loader.sv
module seg_ram_loader
    import seg_ld_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int SUB_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              bank_i,
    input  logic [SUB_W-1:0]  hw_sub_i,
    input  logic              ptr_load_i,
    input  logic [ADDR_W-1:0] ptr_val_i,
    input  logic              sub_load_i,
    input  logic [SUB_W-1:0]  sub_val_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [ROWS-1:0]   rd_data_o
);

    localparam int IMG_W = DEPTH * ROWS;

    mux_mode_e         mode;
    logic [ADDR_W-1:0] ptr_q;
    logic [SUB_W-1:0]  sub_q;
    bit_wr_t           wr [BYTE_W];
    logic [IMG_W-1:0]  image;

    assign mode = mux_mode_e'(mode_i);

    seg_ld_ptr #(.DEPTH(DEPTH), .SUB_W(SUB_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .valid_i    (byte_valid_i),
        .ptr_load_i (ptr_load_i),
        .ptr_val_i  (ptr_val_i),
        .sub_load_i (sub_load_i),
        .sub_val_i  (sub_val_i),
        .ptr_o      (ptr_q),
        .sub_o      (sub_q)
    );

    seg_ld_placer #(.DEPTH(DEPTH), .SUB_W(SUB_W)) u_place (
        .mode_i   (mode),
        .bank_i   (bank_i),
        .valid_i  (byte_valid_i),
        .data_i   (byte_i),
        .ptr_i    (ptr_q),
        .sub_i    (sub_q),
        .hw_sub_i (hw_sub_i),
        .wr_o     (wr)
    );

    seg_ld_ram #(.DEPTH(DEPTH), .PORTS(BYTE_W)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .image_o (image)
    );

    always_comb begin
        rd_data_o = '0;
        if (int'(rd_addr_i) < DEPTH)
            rd_data_o = image[int'(rd_addr_i)*ROWS +: ROWS];
    end

endmodule

// File: rtl/seg_ld_checker.sv
module seg_ld_checker
    import seg_ld_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int SUB_W = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  byte_valid,
    input logic                  ptr_load,
    input logic [ADDR_W-1:0]     ptr_val,
    input logic                  sub_load,
    input logic [SUB_W-1:0]      sub_val,
    input logic [SUB_W-1:0]      hw_sub,
    input logic [ADDR_W-1:0]     ptr,
    input logic [SUB_W-1:0]      sub,
    input logic [DEPTH*ROWS-1:0] image
);

    assert_ptr_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !ptr_load && int'(ptr) < DEPTH) |=> int'(ptr) < DEPTH);

    assert_wrap_bumps_sub_R7: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !ptr_load && !sub_load && int'(ptr) < DEPTH) |=>
        ((ptr < $past(ptr)) ? (sub == SUB_W'($past(sub) + 1'b1)) : (sub == $past(sub))));

    assert_mismatch_no_store_R6: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && sub != hw_sub && int'(ptr) <= DEPTH - BYTE_W) |=> $stable(image));

    assert_ptr_load_R9: assert property (@(posedge clk) disable iff (rst)
        ptr_load |=> ptr == $past(ptr_val));

    assert_sub_load_R9: assert property (@(posedge clk) disable iff (rst)
        sub_load |=> sub == $past(sub_val));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid && !ptr_load && !sub_load) |=>
        ($stable(ptr) && $stable(sub) && $stable(image)));

endmodule

bind seg_ram_loader seg_ld_checker #(.DEPTH(DEPTH), .SUB_W(SUB_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid_i),
    .ptr_load   (ptr_load_i),
    .ptr_val    (ptr_val_i),
    .sub_load   (sub_load_i),
    .sub_val    (sub_val_i),
    .hw_sub     (hw_sub_i),
    .ptr        (ptr_q),
    .sub        (sub_q),
    .image      (image)
);

// File: tb/tb_seg_ram_loader.sv
module tb_seg_ram_loader;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       bank = 1'b0;
    logic [2:0] hw_sub = 3'd0;
    logic       ptr_load = 1'b0;
    logic [4:0] ptr_val = '0;
    logic       sub_load = 1'b0;
    logic [2:0] sub_val = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_d = '0;
    logic [4:0] rd_addr = '0;
    logic [3:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [3:0] mram [24];
    int         mptr;
    int         msub;

    always #10 clk = ~clk;

    seg_ram_loader dut (
        .clk(clk), .rst(rst), .mode_i(mode), .bank_i(bank), .hw_sub_i(hw_sub),
        .ptr_load_i(ptr_load), .ptr_val_i(ptr_val), .sub_load_i(sub_load),
        .sub_val_i(sub_val), .byte_valid_i(byte_valid), .byte_i(byte_d),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    // reference: apply byte with the current model pointer, then loads
    task automatic model_step(input bit v, input logic [7:0] b, input bit pl,
                              input int pv, input bit sl, input int sv);
        int rows, step, a, r, s;
        rows = int'(mode) + 1;
        step = (8 + rows - 1) / rows;
        if (v) begin
            for (int j = 0; j < 8; j++) begin
                a = mptr + j / rows;
                r = j % rows;
                if (bank && mode < 2) r += 2;
                s = msub;
                if (a >= 24) begin a -= 24; s = (msub + 1) % 8; end
                if (s == int'(hw_sub)) mram[a][r] = b[7-j];
            end
            mptr += step;
            if (mptr >= 24) begin mptr -= 24; msub = (msub + 1) % 8; end
        end
        if (pl) mptr = pv;
        if (sl) msub = sv;
    endtask

    task automatic drive(input bit v, input logic [7:0] b, input bit pl,
                         input int pv, input bit sl, input int sv);
        @(negedge clk);
        byte_valid = v; byte_d = b;
        ptr_load = pl; ptr_val = 5'(pv);
        sub_load = sl; sub_val = 3'(sv);
        model_step(v, b, pl, pv, sl, sv);
        @(negedge clk);
        byte_valid = 0; ptr_load = 0; sub_load = 0;
    endtask

    task automatic send(input logic [7:0] b);
        drive(1, b, 0, 0, 0, 0);
    endtask

    task automatic set_ptr(input int p, input int s);
        drive(0, 8'h00, 1, p, 1, s);
    endtask

    task automatic check_ram(input string tag);
        for (int a = 0; a < 24; a++) begin
            rd_addr = 5'(a);
            #1;
            n_tests++;
            if (rd_data !== mram[a]) begin
                n_fail++;
                $display("FAIL %s addr %0d: got %b expected %b", tag, a, rd_data, mram[a]);
            end
        end
    endtask

    task automatic check_val(input string tag, input int a, input logic [3:0] exp);
        rd_addr = 5'(a);
        #1;
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: got %b expected %b", tag, a, rd_data, exp);
        end
    endtask

    initial begin
        for (int a = 0; a < 24; a++) mram[a] = 4'b0;
        mptr = 0; msub = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset contents and out-of-range read
        check_ram("R1 reset");
        check_val("R1 out of range", 30, 4'b0000);

        // R2: static at pointer 0 from reset (also proves pointer reset, R1)
        mode = 2'b00;
        send(8'hA5);
        check_val("R2 static bit7", 0, 4'b0001);
        check_val("R2 static bit6", 1, 4'b0000);
        check_ram("R2 static");
        send(8'h3C);
        check_ram("R2 static step");

        // R3: 1:2 mode
        mode = 2'b01;
        set_ptr(0, 0);
        send(8'hB4);                     // addr0 rows0,1 = 1,0 -> 0001
        check_val("R3 1:2 addr0", 0, 4'b0001);
        send(8'hFF);
        check_ram("R3 1:2");

        // R4: 1:3 row 2 of third address preserved
        mode = 2'b10;
        set_ptr(2, 0);
        send(8'h20);                     // addr2 row2 = 1
        set_ptr(0, 0);
        send(8'hFF);
        check_val("R4 1:3 keep row2", 2, 4'b0111);
        send(8'h00);
        check_ram("R4 1:3");

        // R5: 1:4 mode
        mode = 2'b11;
        set_ptr(10, 0);
        send(8'h9C);
        check_val("R5 1:4 addr10", 10, 4'b1001);
        check_val("R5 1:4 addr11", 11, 4'b0011);
        send(8'h5A);
        check_ram("R5 1:4");

        // R8: bank in static, 1:2, ignored in 1:4
        bank = 1;
        mode = 2'b00;
        set_ptr(16, 0);
        send(8'hFF);
        check_ram("R8 bank static");
        mode = 2'b01;
        set_ptr(12, 0);
        send(8'hC3);
        check_ram("R8 bank 1:2");
        mode = 2'b11;
        set_ptr(20, 0);
        send(8'hF0);
        check_ram("R8 bank ignored 1:4");
        bank = 0;

        // R6: mismatch suppresses store, pointer still advances
        mode = 2'b00;
        hw_sub = 3'd2;
        set_ptr(0, 1);
        send(8'hFF);                     // blocked, ptr -> 8
        hw_sub = 3'd1;
        send(8'h81);                     // lands at 8..15
        check_ram("R6 mismatch then step");

        // R7: crossing inside a 1:3 byte, first part blocked
        mode = 2'b10;
        hw_sub = 3'd3;
        set_ptr(22, 2);
        send(8'hFF);                     // 22,23 blocked; addr0 rows0,1 under sub3
        check_ram("R7 wrap store tail");
        // R7: crossing with first part stored, tail blocked
        set_ptr(22, 3);
        send(8'h00);
        check_ram("R7 wrap store head");
        // R7: static crossing from 23, pointer continues
        mode = 2'b00;
        set_ptr(23, 3);
        send(8'hAA);                     // 23 stored, 0..6 blocked, ptr 7 sub4
        hw_sub = 3'd4;
        send(8'hF0);
        check_ram("R7 static wrap continue");
        // R7: subaddress counter wraps from 7 to 0
        hw_sub = 3'd0;
        set_ptr(20, 7);
        send(8'hFF);
        check_ram("R7 sub counter wrap");

        // R9: load coincident with a byte; byte uses old pointer
        mode = 2'b11;
        set_ptr(4, 0);
        drive(1, 8'h6E, 1, 18, 0, 0);
        send(8'h11);
        check_ram("R9 coincident load");

        // R10: idle cycles hold everything
        repeat (5) @(negedge clk);
        check_ram("R10 idle hold");

        // seeded random mixture
        void'($urandom(32'h5EED_1234));
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 8);
            mode   = 2'($urandom);
            bank   = 1'($urandom);
            hw_sub = 3'($urandom % 2);
            if (op == 0)
                drive(0, 8'h00, 1, int'($urandom % 24), 1, int'($urandom % 2));
            else if (op == 1)
                drive(1, 8'($urandom), 1, 18 + int'($urandom % 6), 0, 0);
            else
                send(8'($urandom));
            case (mode)
                2'b00: check_ram("R2 random");
                2'b01: check_ram("R3 random");
                2'b10: check_ram("R4 random");
                default: check_ram("R5 random");
            endcase
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule